// File: doc/BRIEF.md
# Dual-Pipeline Register Shadowing Decoder

This block sits on a host memory-mapped register bus in front of two identical register files, one for each display pipeline. It decodes every host access from its address, a mode input and a small shadowing control word, and routes the access. Depending on the mode and the control word, a write reaches one file or both files in the same cycle. A read is always answered by exactly one file.

In mosaic mode each pipeline owns a separate address window, so two independent drivers can each reach their own pipeline without disturbing the other. In simultaneous mode a single shared window is used. Writes there are broadcast to both pipelines. The control word can narrow those writes to one copy so that the two copies can differ, and it picks which copy answers reads. The control word sits at its own offset, which is never shadowed, and it can be read back.

Top module: `shadow_regdec`

## Requirements
- R1: Reset (synchronous, active high) sets the control word to 0b011 (write enable A and write enable B set, read select A), clears every register of both files to zero and clears `rdata` to zero.
- R2: In simultaneous mode (`mode_mosaic`=0) with both write-enable bits set, a write into 0x400000–0x7FFFFF updates the register at that index in both files on the same clock edge.
- R3: In simultaneous mode, control bit 0 enables writes to file A and bit 1 enables writes to file B. With only one bit set, a shared-window write changes only that file. With neither set, it changes nothing.
- R4: In simultaneous mode, a shared-window read returns file A when control bit 2 is 0 and file B when it is 1.
- R5: In mosaic mode (`mode_mosaic`=1), 0x400000–0x7FFFFF reads and writes only file A, and 0xC00000–0xFFFFFF reads and writes only file B. The control word's enable and select bits have no effect.
- R6: In simultaneous mode, accesses to 0xC00000–0xFFFFFF are ignored and reads there return zero.
- R7: In either mode, an access outside the valid windows that does not hit the control offset is ignored and reads zero. This covers 0x000000–0x3FFFFF apart from the control word, and 0x800000–0xBFFFFF.
- R8: The control word is at byte offset 0x000100 in both modes. A write stores `wdata[2:0]` and ignores the other bits. A read returns the word zero-extended.
- R9: The register index is `addr[IDX_W+1:2]`, so there are NUM_REGS 32-bit registers per file. Address bits 1:0 and the bits between the index and the window bits are ignored, which means the registers repeat through each window.
- R10: Read data is registered. It appears on `rdata` on the clock edge that samples `rd_en`, is visible after that edge, and holds while `rd_en` is low.
- R11: When a read and a write to the same register happen in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_mosaic | input | 1 | 0 = simultaneous (shared window), 1 = mosaic (split windows); sampled with each access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (24) | Byte address of the access |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |

## Verification
The hardest state to reach from the ports is two copies of the same register that hold different values. Only a simultaneous-mode write made under a narrowed enable mask can create it, and a single read path can only show it one copy at a time. The stimulus first narrows the mask through the control offset and writes through the shared window. It then shows the copy that was written and the one left alone, either by flipping the read-select bit or by switching to mosaic mode and reading each pipeline's own window. A same-cycle read and write to one register is driven on purpose to show that the read returns the value from before the write.

// File: rtl/shd_pkg.sv
`timescale 1ns/1ps
package shd_pkg;

    localparam int NUM_PIPES = 2;
    localparam int CTRL_W    = 3;

    // Which address window an access falls into (by the top two address bits).
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_LO   = 2'd1,
        WIN_HI   = 2'd2
    } win_e;

    // Shadowing control word; bit 0 = wen_a, bit 1 = wen_b, bit 2 = rd_sel_b.
    typedef struct packed {
        logic rd_sel_b;
        logic wen_b;
        logic wen_a;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{rd_sel_b: 1'b0, wen_b: 1'b1, wen_a: 1'b1};

    // Routing decision for one access.
    typedef struct packed {
        logic       ctrl_hit;
        logic [1:0] wr_mask;   // bit p = write file p
        logic       rd_ok;     // a file answers the read
        logic       rd_b;      // that file is B
    } access_t;

    function automatic win_e win_of(logic [1:0] top);
        case (top)
            2'b01:   return WIN_LO;
            2'b11:   return WIN_HI;
            default: return WIN_NONE;
        endcase
    endfunction

    function automatic access_t route(win_e win, logic mosaic, ctrl_t c, logic ctrl_hit);
        access_t a;
        a = '0;
        if (ctrl_hit) begin
            a.ctrl_hit = 1'b1;
        end else if (mosaic) begin
            if (win == WIN_LO) begin
                a.wr_mask = 2'b01;
                a.rd_ok   = 1'b1;
                a.rd_b    = 1'b0;
            end else if (win == WIN_HI) begin
                a.wr_mask = 2'b10;
                a.rd_ok   = 1'b1;
                a.rd_b    = 1'b1;
            end
        end else if (win == WIN_LO) begin
            a.wr_mask = {c.wen_b, c.wen_a};
            a.rd_ok   = 1'b1;
            a.rd_b    = c.rd_sel_b;
        end
        return a;
    endfunction

endpackage

// File: rtl/shd_decode.sv
`timescale 1ns/1ps
module shd_decode
    import shd_pkg::*;
#(
    parameter int              ADDR_W   = 24,
    parameter int              IDX_W    = 4,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 24'h000100
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mosaic,
    input  ctrl_t             ctrl,
    output access_t           acc,
    output logic [IDX_W-1:0]  idx
);
    logic ctrl_hit;
    win_e win;
    logic unused_lsbs;

    assign ctrl_hit    = (addr[ADDR_W-1:2] == CTRL_OFS[ADDR_W-1:2]);
    assign win         = win_of(addr[ADDR_W-1 -: 2]);
    assign idx         = addr[IDX_W+1:2];
    assign acc         = route(win, mosaic, ctrl, ctrl_hit);
    assign unused_lsbs = ^addr[1:0];

endmodule

// File: rtl/shd_ctrl_reg.sv
`timescale 1ns/1ps
module shd_ctrl_reg
    import shd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= CTRL_RESET;
        end else if (we) begin
            q <= ctrl_t'(wdata);
        end
    end
endmodule

// File: rtl/shd_regfile.sv
`timescale 1ns/1ps
module shd_regfile #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/shadow_regdec.sv
`timescale 1ns/1ps
module shadow_regdec
    import shd_pkg::*;
#(
    parameter int                ADDR_W   = 24,
    parameter int                DATA_W   = 32,
    parameter int                NUM_REGS = 16,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 24'h000100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_mosaic,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = $clog2(NUM_REGS);

    access_t                acc;
    logic [IDX_W-1:0]       idx;
    ctrl_t                  ctrl_q;
    logic                   ctrl_we;
    logic [NUM_PIPES-1:0]   file_we;
    logic [DATA_W-1:0]      file_rd [NUM_PIPES];
    logic [DATA_W-1:0]      rd_next;

    shd_decode #(
        .ADDR_W   (ADDR_W),
        .IDX_W    (IDX_W),
        .CTRL_OFS (CTRL_OFS)
    ) decode_i (
        .addr   (addr),
        .mosaic (mode_mosaic),
        .ctrl   (ctrl_q),
        .acc    (acc),
        .idx    (idx)
    );

    assign ctrl_we = wr_en & acc.ctrl_hit;

    shd_ctrl_reg ctrl_i (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl_we),
        .wdata (wdata[CTRL_W-1:0]),
        .q     (ctrl_q)
    );

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        assign file_we[p] = wr_en & acc.wr_mask[p];

        shd_regfile #(
            .DATA_W   (DATA_W),
            .NUM_REGS (NUM_REGS)
        ) file_i (
            .clk   (clk),
            .rst   (rst),
            .we    (file_we[p]),
            .idx   (idx),
            .wdata (wdata),
            .rdata (file_rd[p])
        );
    end

    always_comb begin
        if (acc.ctrl_hit) begin
            rd_next = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        end else if (acc.rd_ok) begin
            rd_next = file_rd[acc.rd_b];
        end else begin
            rd_next = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_next;
        end
    end

endmodule

// File: rtl/shd_regdec_chk.sv
`timescale 1ns/1ps
module shd_regdec_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mode_mosaic,
    input logic              wr_en,
    input logic              rd_en,
    input logic [1:0]        addr_top,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        file_we,
    input logic [2:0]        ctrl
);
    AST_CTRL_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ctrl == 3'b011)); // R1

    AST_BROADCAST: assert property (@(posedge clk) disable iff (rst)
        (!mode_mosaic && wr_en && addr_top == 2'b01 && ctrl[1:0] == 2'b11)
        |-> (file_we == 2'b11)); // R2

    AST_SHARED_MASK: assert property (@(posedge clk) disable iff (rst)
        (!mode_mosaic && wr_en && addr_top == 2'b01) |-> (file_we == ctrl[1:0])); // R3

    AST_MOSAIC_ONE_FILE: assert property (@(posedge clk) disable iff (rst)
        mode_mosaic |-> $onehot0(file_we)); // R5

    AST_MOSAIC_B_SPARES_A: assert property (@(posedge clk) disable iff (rst)
        (mode_mosaic && addr_top == 2'b11) |-> !file_we[0]); // R5

    AST_SHARED_HI_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!mode_mosaic && addr_top == 2'b11) |-> (file_we == 2'b00)); // R6

    AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr_top == 2'b10) |=> (rdata == '0)); // R7

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (file_we == 2'b00)); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata)); // R10
endmodule

bind shadow_regdec shd_regdec_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .mode_mosaic (mode_mosaic),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr_top    (addr[ADDR_W-1 -: 2]),
    .rdata       (rdata),
    .file_we     (file_we),
    .ctrl        (ctrl_q)
);

// File: tb/shadow_regdec_tb_top.sv
`timescale 1ns/1ps
module shadow_regdec_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_mosaic = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [23:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    shadow_regdec dut_i (
        .clk         (clk),
        .rst         (rst),
        .mode_mosaic (mode_mosaic),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata)
    );

    typedef struct packed {
        logic        is_rd;
        logic        mos;
        logic [23:0] a;
        logic [31:0] d;    // write data, or expected read data
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 45;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 24'h400008, 32'hDEAD0001, 8'd2},  // R2 broadcast idx 2
        '{1'b1, 1'b0, 24'h400008, 32'hDEAD0001, 8'd2},  // R2 copy A
        '{1'b1, 1'b1, 24'hC00008, 32'hDEAD0001, 8'd2},  // R2 copy B
        '{1'b0, 1'b0, 24'h000100, 32'h00000001, 8'd8},  // R8 ctrl = A only
        '{1'b1, 1'b0, 24'h000100, 32'h00000001, 8'd8},  // R8 readback
        '{1'b0, 1'b0, 24'h400008, 32'h11111111, 8'd3},  // R3 A only
        '{1'b1, 1'b1, 24'h400008, 32'h11111111, 8'd3},  // R3
        '{1'b1, 1'b1, 24'hC00008, 32'hDEAD0001, 8'd3},  // R3 B untouched
        '{1'b0, 1'b0, 24'h000100, 32'h00000006, 8'd8},  // R8 ctrl = B only, read B
        '{1'b0, 1'b0, 24'h40000C, 32'h22222222, 8'd3},  // R3 B only idx 3
        '{1'b1, 1'b0, 24'h40000C, 32'h22222222, 8'd4},  // R4 read B
        '{1'b0, 1'b0, 24'h000100, 32'h00000002, 8'd8},  // R8 read select A
        '{1'b1, 1'b0, 24'h40000C, 32'h00000000, 8'd4},  // R4 A idx 3 untouched
        '{1'b1, 1'b0, 24'h400008, 32'h11111111, 8'd4},  // R4 A idx 2
        '{1'b0, 1'b0, 24'h000100, 32'h00000000, 8'd8},  // R8 no enables
        '{1'b0, 1'b0, 24'h400010, 32'h33333333, 8'd3},  // R3 dropped
        '{1'b1, 1'b1, 24'h400010, 32'h00000000, 8'd3},  // R3
        '{1'b1, 1'b1, 24'hC00010, 32'h00000000, 8'd3},  // R3
        '{1'b0, 1'b0, 24'h000100, 32'h00000003, 8'd8},  // R8
        '{1'b0, 1'b1, 24'h400014, 32'hAAAA0005, 8'd5},  // R5 mosaic A
        '{1'b1, 1'b1, 24'hC00014, 32'h00000000, 8'd5},  // R5 B untouched
        '{1'b1, 1'b1, 24'h400014, 32'hAAAA0005, 8'd5},  // R5
        '{1'b0, 1'b1, 24'hC00018, 32'hBBBB0006, 8'd5},  // R5 mosaic B
        '{1'b1, 1'b1, 24'h400018, 32'h00000000, 8'd5},  // R5 A untouched
        '{1'b1, 1'b1, 24'hC00018, 32'hBBBB0006, 8'd5},  // R5
        '{1'b0, 1'b0, 24'h000100, 32'h00000004, 8'd8},  // R8 no enables, read B
        '{1'b0, 1'b1, 24'h40001C, 32'h12340007, 8'd5},  // R5 enables ignored
        '{1'b1, 1'b1, 24'h40001C, 32'h12340007, 8'd5},  // R5 select ignored
        '{1'b0, 1'b0, 24'h000100, 32'h00000007, 8'd8},  // R8
        '{1'b0, 1'b0, 24'hC00020, 32'h44444444, 8'd6},  // R6 ignored write
        '{1'b1, 1'b0, 24'hC00020, 32'h00000000, 8'd6},  // R6 reads zero
        '{1'b1, 1'b1, 24'hC00020, 32'h00000000, 8'd6},  // R6 B idx 8 clean
        '{1'b1, 1'b0, 24'h400020, 32'h00000000, 8'd6},  // R6 via shared read B
        '{1'b0, 1'b1, 24'h800024, 32'h55555555, 8'd7},  // R7 hole write
        '{1'b0, 1'b0, 24'h000024, 32'h55555555, 8'd7},  // R7 low hole write
        '{1'b1, 1'b1, 24'h800024, 32'h00000000, 8'd7},  // R7
        '{1'b1, 1'b1, 24'h400024, 32'h00000000, 8'd7},  // R7 A clean
        '{1'b1, 1'b1, 24'hC00024, 32'h00000000, 8'd7},  // R7 B clean
        '{1'b0, 1'b1, 24'h7FFFC3, 32'h66666666, 8'd9},  // R9 aliases idx 0
        '{1'b1, 1'b1, 24'h400000, 32'h66666666, 8'd9},  // R9
        '{1'b1, 1'b1, 24'hC00000, 32'h00000000, 8'd9},  // R9
        '{1'b1, 1'b1, 24'h000100, 32'h00000007, 8'd8},  // R8 mosaic readback
        '{1'b0, 1'b1, 24'h000100, 32'hFFFFFFF9, 8'd8},  // R8 upper bits dropped
        '{1'b1, 1'b1, 24'h000100, 32'h00000001, 8'd8},  // R8
        '{1'b1, 1'b0, 24'h000104, 32'h00000000, 8'd7}   // R7 next to ctrl
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic mos, input logic [23:0] a, input logic [31:0] d);
        @(negedge clk);
        mode_mosaic = mos; addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic mos, input logic [23:0] a, input logic [31:0] exp,
                           input int req, input string what);
        @(negedge clk);
        mode_mosaic = mos; addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, rdata, exp, what);
    endtask

    initial begin
        #500000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(1, rdata, 32'h0, "rdata in reset");                    // R1
        rst = 1'b0;
        do_read(1'b0, 24'h000100, 32'h3, 1, "ctrl after reset");     // R1
        do_read(1'b1, 24'hC00004, 32'h0, 1, "file B cleared");       // R1

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_rd) begin
                do_read(VECS[i].mos, VECS[i].a, VECS[i].d, int'(VECS[i].req), "table read");
            end else begin
                do_write(VECS[i].mos, VECS[i].a, VECS[i].d);
            end
        end

        // R11: same-cycle read and write of one register
        do_write(1'b0, 24'h000100, 32'h3);
        @(negedge clk);
        mode_mosaic = 1'b0; addr = 24'h400028; wdata = 32'h77777777;
        wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(11, rdata, 32'h0, "read before write");
        do_read(1'b0, 24'h400028, 32'h77777777, 11, "write landed");

        // R10: latency and hold
        @(negedge clk);
        mode_mosaic = 1'b0; addr = 24'h400008; rd_en = 1'b1;
        #2;
        check(10, rdata, 32'h77777777, "old data before edge");
        @(negedge clk);
        rd_en = 1'b0;
        check(10, rdata, 32'h11111111, "new data after edge");
        addr = 24'h40000C;
        repeat (2) @(negedge clk);
        check(10, rdata, 32'h11111111, "held while idle");

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(1, rdata, 32'h0, "rdata cleared by reset");
        rst = 1'b0;
        do_read(1'b1, 24'h000100, 32'h3, 1, "ctrl restored");
        do_read(1'b1, 24'h400008, 32'h0, 1, "file A cleared");
        do_read(1'b1, 24'hC00008, 32'h0, 1, "file B cleared");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule